// File: doc/BRIEF.md
# HDLC Frame Receiver

This block turns a serial HDLC line into bytes. It takes one line bit on each clock where the bit strobe is high. It finds the opening flag and removes the zeros that the sender inserted after runs of five ones. It passes the recovered bytes downstream, least significant bit first, one byte per output beat. The beat that closes each frame carries a last marker and a one-hot status word.

The receiver needs no setting to tell which kind of fill sits between frames. It accepts repeated flags, flags that share their zero with the flag before them, and long runs of ones. A single control input chooses between a 16-bit frame check and no check. In check mode, the two check bytes are consumed by the receiver and are never forwarded. Every frame that contained any data bits ends with exactly one last beat. That beat reports one of four outcomes: good, check error, abort, or bad length.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset `out_valid` is low, and the receiver stays silent while it hunts for a flag. A byte stream that contains no flag yields no beats.
- R2: The pattern 0, six 1s, 0 is a flag wherever it occurs, including when its leading 0 is the closing 0 of the previous flag. One flag between two frames both closes the first frame and opens the second, and both frames are received in full.
- R3: A run of seven or more 1s after a flag is accepted as idle fill without any configuration. It produces no beat, and the next flag opens a frame normally.
- R4: Inside a frame, a 0 that follows five consecutive 1s is removed and never reaches the byte output.
- R5: Each byte is assembled with the first received bit as bit 0 of `out_data`. `out_last` is high only on the final beat of a frame. `out_status` is 0 on every other beat.
- R6: With `crc_en`=1, the last two bytes before the closing flag are withheld. The frame is good when the check register (reflected polynomial 0x8408, preset 0xFFFF, shifted LSB first over data and check bytes) ends at 0xF0B8. A good frame has `out_status`=4'b0001.
- R7: With `crc_en`=1, a frame whose check register does not end at 0xF0B8 is still forwarded. Its last beat has `out_status`=4'b0010.
- R8: With `crc_en`=0, every byte of the frame is forwarded. The final byte carries `out_last` and `out_status`=4'b0001.
- R9: Seven consecutive 1s inside a frame that already holds data bits abort it. Bytes that had already left the hold stage stay delivered. A final beat follows with `out_data`=0, `out_last`=1 and `out_status`=4'b0100.
- R10: A frame has bad length if its bit count is not a multiple of 8, or if it holds fewer whole bytes than the hold depth (3 with the check, 1 without). Its last beat has `out_status`=4'b1000. If no held byte is available, that beat carries `out_data`=0.
- R11: A flag that directly follows a flag, with no data bits between them, produces no beat.
- R12: `rx_bit` is ignored on clocks where `bit_en` is low, and `out_valid` only rises on the clock after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line bit strobe, one bit per high cycle |
| rx_bit | input | 1 | Serial line bit |
| crc_en | input | 1 | 1 = 16-bit frame check, 0 = no check |
| out_valid | output | 1 | Output beat valid (one cycle) |
| out_data | output | DATA_W | Received byte, first bit in bit 0 |
| out_last | output | 1 | Final beat of a frame |
| out_status | output | 4 | On last beat: bit0 good, bit1 check error, bit2 abort, bit3 bad length |

## Verification
Two events can land on the same strobe. One is the report of the frame that is closing. The other is the clearing of the bit-collection state, which then starts the next frame. The bench provokes this by sending frames back to back with only one flag between them, or with one shared-zero flag. It judges the result by the next frame: its bytes, last marker and status must match the model, with nothing lost or merged across the boundary. Random gaps between strobes carry noise on `rx_bit`. This shows that the close and restart depend only on strobed bits.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // Outcome reported on the final beat of a frame; exactly one bit set.
  typedef struct packed {
    logic short_len;  // bit 3
    logic aborted;    // bit 2
    logic crc_bad;    // bit 1
    logic good;       // bit 0
  } rx_stat_t;

endpackage

// File: rtl/hdlc_rx_linecode.sv
// Classifies each strobed line bit: flag, abort, stuffed zero, or data bit.
module hdlc_rx_linecode #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_push
);
  localparam int RUN_MAX = FLAG_ONES + 1;
  localparam int RW      = $clog2(RUN_MAX + 1);

  logic [RW-1:0] run_q, run_d;
  logic          infr_q, infr_d;
  logic          at_flag_run, at_stuff_run;

  always_comb begin
    at_flag_run  = (run_q == RW'(FLAG_ONES));
    at_stuff_run = (run_q == RW'(FLAG_ONES - 1));
    ev_flag  = bit_en & ~rx_bit & at_flag_run;
    ev_abort = bit_en & rx_bit & at_flag_run & infr_q;
    ev_push  = bit_en & infr_q & ~at_flag_run & ~(~rx_bit & at_stuff_run);
    run_d  = run_q;
    infr_d = infr_q;
    if (bit_en) begin
      if (!rx_bit)                    run_d = '0;
      else if (run_q != RW'(RUN_MAX)) run_d = run_q + 1'b1;
      if (ev_flag)       infr_d = 1'b1;
      else if (ev_abort) infr_d = 1'b0;
    end
  end

  // Run counter starts saturated so a flag needs a real leading zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= RW'(RUN_MAX);
      infr_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      infr_q <= infr_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_flagdelay.sv
// Holds the newest DEPTH destuffed bits so flag bits never reach the bytes.
module hdlc_rx_flagdelay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic din,
  output logic dout_vld,
  output logic dout
);
  localparam int NW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] line_q, line_d;
  logic [NW-1:0]    cnt_q, cnt_d;

  always_comb begin
    dout_vld = push & (cnt_q == NW'(DEPTH));
    dout     = line_q[0];
    line_d   = push ? {din, line_q[DEPTH-1:1]} : line_q;
    cnt_d    = cnt_q;
    if (clr)                               cnt_d = '0;
    else if (push && cnt_q != NW'(DEPTH))  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    line_q <= line_d;
  end

endmodule

// File: rtl/hdlc_rx_crc.sv
// Reflected serial check register, first bit in at bit 0.
module hdlc_rx_crc #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = crc[0] ^ din;
    crc_d = crc;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = {1'b0, crc[W-1:1]} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= INIT;
    else        crc <= crc_d;
  end

endmodule

// File: rtl/hdlc_rx_framer.sv
// Byte assembly, check-byte holdback and end-of-frame reporting.
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               HOLD_MAX = 3,
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_en,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              close_ev,
  input  logic              abort_ev,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output rx_stat_t          out_stat
);
  localparam int BW = $clog2(DATA_W);
  localparam int HW = $clog2(HOLD_MAX + 1);

  logic [DATA_W-1:0] sh_q, sh_d, byte_nx;
  logic [BW-1:0]     bpos_q, bpos_d;
  logic [DATA_W-1:0] hold_q [HOLD_MAX];
  logic [DATA_W-1:0] hold_d [HOLD_MAX];
  logic [HW-1:0]     hc_q, hc_d, depth;
  logic              seen_q, seen_d;
  logic              ov, ol;
  logic [DATA_W-1:0] od;
  rx_stat_t          ost;

  always_comb begin
    depth   = crc_en ? HW'(HOLD_MAX) : HW'(1);
    byte_nx = {bit_val, sh_q[DATA_W-1:1]};
    sh_d    = sh_q;
    bpos_d  = bpos_q;
    hold_d  = hold_q;
    hc_d    = hc_q;
    seen_d  = seen_q;
    ov      = 1'b0;
    ol      = 1'b0;
    od      = '0;
    ost     = '0;
    if (close_ev || abort_ev) begin
      if (seen_q) begin
        ov = 1'b1;
        ol = 1'b1;
        if (abort_ev)            ost.aborted = 1'b1;
        else if (hc_q != depth)  ost.short_len = 1'b1;
        else begin
          od = hold_q[0];
          if (bpos_q != '0)                      ost.short_len = 1'b1;
          else if (crc_en && crc_val != CRC_GOOD) ost.crc_bad  = 1'b1;
          else                                   ost.good     = 1'b1;
        end
      end
      bpos_d = '0;
      hc_d   = '0;
      seen_d = 1'b0;
    end else if (bit_vld) begin
      seen_d = 1'b1;
      sh_d   = byte_nx;
      if (bpos_q == BW'(DATA_W - 1)) begin
        bpos_d = '0;
        if (hc_q == depth) begin
          ov = 1'b1;
          od = hold_q[0];
          for (int i = 0; i < HOLD_MAX - 1; i++) begin
            if (HW'(i) < depth - 1'b1) hold_d[i] = hold_q[i+1];
          end
          hold_d[depth - 1'b1] = byte_nx;
        end else begin
          hold_d[hc_q] = byte_nx;
          hc_d         = hc_q + 1'b1;
        end
      end else begin
        bpos_d = bpos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpos_q    <= '0;
      hc_q      <= '0;
      seen_q    <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_stat  <= '0;
    end else begin
      bpos_q    <= bpos_d;
      hc_q      <= hc_d;
      seen_q    <= seen_d;
      out_valid <= ov;
      out_last  <= ol;
      out_data  <= od;
      out_stat  <= ost;
    end
  end

  always_ff @(posedge clk) begin
    sh_q   <= sh_d;
    hold_q <= hold_d;
  end

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'hF0B8,
  parameter int               FLAG_ONES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              crc_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [3:0]        out_status
);
  localparam int HOLD_MAX = CRC_W / DATA_W + 1;
  localparam int DELAY    = FLAG_ONES + 1;

  logic             ev_flag, ev_abort, ev_push;
  logic             cb_vld, cb_val;
  logic [CRC_W-1:0] crc_val;
  rx_stat_t         stat;

  hdlc_rx_linecode #(.FLAG_ONES(FLAG_ONES)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_push(ev_push)
  );

  hdlc_rx_flagdelay #(.DEPTH(DELAY)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(ev_flag | ev_abort), .push(ev_push),
    .din(rx_bit), .dout_vld(cb_vld), .dout(cb_val)
  );

  hdlc_rx_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ev_flag | ev_abort), .en(cb_vld),
    .din(cb_val), .crc(crc_val)
  );

  hdlc_rx_framer #(
    .DATA_W(DATA_W), .HOLD_MAX(HOLD_MAX), .CRC_W(CRC_W), .CRC_GOOD(CRC_GOOD)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .bit_vld(cb_vld),
    .bit_val(cb_val), .close_ev(ev_flag), .abort_ev(ev_abort),
    .crc_val(crc_val), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_stat(stat)
  );

  assign out_status = stat;

endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic [3:0]        out_status
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_mid_status_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_status == 4'b0000));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> ($countones(out_status) == 1));

  p_abort_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status[2]) |-> (out_last && out_data == '0));

  p_beat_follows_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> !out_valid);

endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .out_status(out_status)
);

// File: tb/sim_hdlc_frame_rx.sv
module sim_hdlc_frame_rx;

  logic       clk = 1'b0;
  logic       rst_n, bit_en, rx_bit, crc_en;
  logic       out_valid, out_last;
  logic [7:0] out_data;
  logic [3:0] out_status;

  int n_checks = 0;
  int n_fail   = 0;
  int tx_ones  = 0;

  logic [7:0] pay [16];
  logic [7:0] exp_d [64];
  logic       exp_l [64];
  logic [3:0] exp_s [64];
  logic [7:0] got_d [64];
  logic       got_l [64];
  logic [3:0] got_s [64];
  int exp_n = 0;
  int got_n = 0;

  always #4 clk = ~clk;

  hdlc_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .crc_en(crc_en),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_status(out_status)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 64) begin
      got_d[got_n] = out_data;
      got_l[got_n] = out_last;
      got_s[got_n] = out_status;
      got_n++;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One line bit; noise on rx_bit while the strobe is low (R12).
  task automatic strobe(input logic b);
    int gap = $urandom_range(2, 0);
    repeat (gap) begin
      @(negedge clk); bit_en = 1'b0; rx_bit = 1'($urandom_range(1, 0));
    end
    @(negedge clk); bit_en = 1'b1; rx_bit = b;
    @(negedge clk); bit_en = 1'b0; rx_bit = 1'($urandom_range(1, 0));
  endtask

  task automatic put_data(input logic b);
    strobe(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin strobe(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) put_data(b[i]);
  endtask

  task automatic put_flag();
    strobe(1'b0);
    repeat (6) strobe(1'b1);
    strobe(1'b0);
    tx_ones = 0;
  endtask

  task automatic put_shared();
    repeat (6) strobe(1'b1);
    strobe(1'b0);
    tx_ones = 0;
  endtask

  task automatic expect_beat(input logic [7:0] d, input logic l, input logic [3:0] s);
    exp_d[exp_n] = d; exp_l[exp_n] = l; exp_s[exp_n] = s; exp_n++;
  endtask

  function automatic logic [15:0] calc_fcs(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ pay[i][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic compare(input string req);
    repeat (3) @(negedge clk);
    check(got_n == exp_n, req, 16'(got_n), 16'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      check({got_l[i], got_s[i], got_d[i]} == {exp_l[i], exp_s[i], exp_d[i]}, req,
            {3'b0, got_l[i], got_s[i], got_d[i]}, {3'b0, exp_l[i], exp_s[i], exp_d[i]});
    got_n = 0;
    exp_n = 0;
  endtask

  // Frame after an opening flag: payload, check bytes in check mode, closing flag.
  task automatic frame_ok(input int n, input bit corrupt, input bit preset);
    logic [15:0] f;
    for (int i = 0; i < n; i++) begin
      if (!preset) pay[i] = 8'($urandom);
      put_byte(pay[i]);
    end
    if (crc_en) begin
      f = calc_fcs(n);
      if (corrupt) f = f ^ 16'h0010;
      put_byte(f[7:0]);
      put_byte(f[15:8]);
    end
    put_flag();
    if (crc_en && n == 0) expect_beat(8'h00, 1'b1, 4'b1000);
    else
      for (int i = 0; i < n; i++)
        expect_beat(pay[i], i == n - 1,
                    (i == n - 1) ? ((crc_en && corrupt) ? 4'b0010 : 4'b0001) : 4'b0000);
  endtask

  // n bytes, last one ending in 0, then seven ones; reopens with a flag.
  task automatic frame_abort(input int n);
    int dep = crc_en ? 3 : 1;
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'($urandom);
      if (i == n - 1) pay[i][7] = 1'b0;
      put_byte(pay[i]);
    end
    repeat (7) strobe(1'b1);
    tx_ones = 0;
    for (int i = 0; i < n - 1 - dep; i++) expect_beat(pay[i], 1'b0, 4'b0000);
    expect_beat(8'h00, 1'b1, 4'b0100);
    put_flag();
  endtask

  // n whole bytes plus k extra bits, no check bytes.
  task automatic frame_odd(input int n, input int k);
    int dep = crc_en ? 3 : 1;
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'($urandom);
      put_byte(pay[i]);
    end
    for (int i = 0; i < k; i++) put_data(1'($urandom_range(1, 0)));
    put_flag();
    if (n >= dep) begin
      for (int i = 0; i < n - dep; i++) expect_beat(pay[i], 1'b0, 4'b0000);
      expect_beat(pay[n - dep], 1'b1, 4'b1000);
    end else expect_beat(8'h00, 1'b1, 4'b1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (whole run) actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; crc_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset", 16'(out_valid), 16'h0);

    // R1: no flag yet -> silence
    for (int i = 0; i < 4; i++) put_byte(8'($urandom));
    compare("R1 hunt");
    put_flag();

    // R4: payload dense in ones forces many stuffed zeros
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'h3F; pay[4] = 8'hF8;
    frame_ok(5, 1'b0, 1'b1);
    compare("R4 destuff");

    frame_ok(3, 1'b0, 1'b0);
    compare("R6 good check");
    frame_ok(4, 1'b1, 1'b0);
    compare("R7 check error");

    crc_en = 1'b0;
    frame_ok(6, 1'b0, 1'b0);
    compare("R8 no check");

    // R2: back-to-back frames sharing one flag, then a shared-zero flag
    frame_ok(2, 1'b0, 1'b0);
    frame_ok(3, 1'b0, 1'b0);
    put_shared();
    frame_ok(2, 1'b0, 1'b0);
    compare("R2 shared flags");

    // R11: empty flag-to-flag gaps
    put_flag();
    put_flag();
    frame_ok(0, 1'b0, 1'b0);
    compare("R11 empty");

    // R3: ones fill then a frame in check mode
    repeat (10) strobe(1'b1);
    crc_en = 1'b1;
    put_flag();
    frame_ok(2, 1'b0, 1'b0);
    compare("R3 ones fill");

    // R12: noise with strobe low must not disturb the open frame
    repeat (40) begin
      @(negedge clk); bit_en = 1'b0; rx_bit = 1'($urandom_range(1, 0));
    end
    frame_ok(3, 1'b0, 1'b0);
    compare("R12 strobe gating");

    frame_abort(5);
    compare("R9 abort check mode");
    crc_en = 1'b0;
    frame_abort(2);
    compare("R9 abort plain");

    frame_odd(3, 3);
    compare("R10 misaligned");
    crc_en = 1'b1;
    frame_odd(4, 5);
    compare("R10 misaligned check");
    frame_ok(0, 1'b0, 1'b0);
    compare("R10 short check");

    // R5 and mixed: constrained random frames and fills
    for (int it = 0; it < 40; it++) begin
      int kind = $urandom_range(9, 0);
      string tag;
      if (kind <= 5) begin
        int n = $urandom_range(7, 0);
        bit bad = ($urandom_range(3, 0) == 0) && n > 0;
        tag = crc_en ? (n == 0 ? "R10 rand" : (bad ? "R7 rand" : "R6 rand"))
                     : (n == 0 ? "R11 rand" : "R8 rand");
        frame_ok(n, bad, 1'b0);
      end else if (kind <= 7) begin
        tag = "R9 rand";
        frame_abort($urandom_range(6, 1));
      end else begin
        tag = "R10 rand";
        frame_odd($urandom_range(5, 0), $urandom_range(7, 1));
      end
      compare(tag);
      case ($urandom_range(3, 0))
        0: ;
        1: put_shared();
        2: put_flag();
        default: begin
          repeat (7 + $urandom_range(5, 0)) strobe(1'b1);
          tx_ones = 0;
          put_flag();
        end
      endcase
      crc_en = 1'($urandom_range(1, 0));
      compare("R5 fill");
    end

    report();
    $finish;
  end

endmodule